// File: doc/BRIEF.md
# Multiprocessor Hardware Lock Unit

This block keeps a set of lock variables in its own storage, away from main memory, for a multiprocessor on a shared bus. A processor claims a lock by reading its address and gives it up by writing to the same address. The read is an atomic test-and-set: in the cycle of the read the unit answers whether the claim succeeded, and from the next clock edge the lock belongs to that processor. One-hot select lines name the processor behind each access. Each access takes one cycle and is never stalled, so the port has no back-pressure. It is a plain request/response interface and does not use valid/ready.

The locks fall into two pools. Low addresses hold locks for short critical sections. A processor that is refused one of these simply tries again. High addresses hold locks for long critical sections, and each of these keeps one waiting bit per processor. When the owner of a long lock releases it while processors are waiting, the unit gives the lock straight to the lowest-numbered waiter. It then sends that processor a single-cycle interrupt, so that no processor has to poll the bus while it waits.

Top module: `hw_lock_unit`

## Requirements
- R1: Reset frees every lock, clears every owner and waiting bit, and holds `cpu_irq` at zero.
- R2: A read of a free lock returns `rd_grant`=1 in the same cycle. From the next edge the lock is held, with the reader as its owner.
- R3: A read of a held lock returns `rd_grant`=0. On a long lock (address >= SHORT_LOCKS) the reader's waiting bit is set, unless the reader is the owner.
- R4: A write to a lock from a processor that is not its owner changes nothing.
- R5: When the owner writes to a lock that has no waiters, the lock becomes free.
- R6: When the owner writes to a long lock that has waiters, ownership passes to the lowest-numbered waiter and that waiter's bit is cleared. Bit k of `cpu_irq` (k = the new owner's number) is high for exactly the one cycle after the write.
- R7: A short lock (address < SHORT_LOCKS) never records waiters and never raises `cpu_irq`. Its owner's write always frees it.
- R8: An access counts only if `cpu_sel` is one-hot and exactly one of `rd_en`/`wr_en` is high. Any other combination is ignored and gives `rd_grant`=0. `rd_grant` is 0 whenever the access is not a read.
- R9: At most one bit of `cpu_irq` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | NUM_CPU | One-hot select; bit k marks processor k as the requester |
| lock_addr | input | clog2(SHORT_LOCKS+LONG_LOCKS) | Lock index; short pool first, then long pool |
| rd_en | input | 1 | Acquire attempt |
| wr_en | input | 1 | Release |
| rd_grant | output | 1 | Same-cycle result of an acquire: 1 = lock taken |
| cpu_irq | output | NUM_CPU | Registered wake-up pulse for the processor that has been handed a lock |

## Verification
Three processors contend for one long lock, and the owner also tries to re-acquire it. The interrupt line that fires on release then shows whether the hand-over picks the lowest waiter, and whether the owner was wrongly queued behind itself. The same contention on a short lock must free the lock and raise no interrupt, which separates the two pools. Writes from non-owners, accesses with several select lines high, and cycles with both enables high are each followed by a read that reveals whether the lock state was disturbed. A reset issued while a lock is held with waiters queued must leave the lock free to take.

// File: rtl/hlu_pkg.sv
package hlu_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ACQ  = 2'd1,
    OP_REL  = 2'd2
  } lock_op_e;
endpackage

// File: rtl/hlu_decode.sv
module hlu_decode
  import hlu_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LOCKS = 128,
  parameter int AW        = 7,
  parameter int IDW       = 2
) (
  input  logic [NUM_CPU-1:0]   cpu_sel,
  input  logic [AW-1:0]        lock_addr,
  input  logic                 rd_en,
  input  logic                 wr_en,
  output lock_op_e             op,
  output logic [IDW-1:0]       req_id,
  output logic [NUM_LOCKS-1:0] lock_hit
);
  logic sel_ok;
  logic any_hit;

  assign sel_ok = (cpu_sel != '0) && ((cpu_sel & (cpu_sel - 1'b1)) == '0);

  always_comb begin
    req_id = '0;
    for (int k = 0; k < NUM_CPU; k++) begin
      if (cpu_sel[k]) req_id = IDW'(k);
    end
  end

  always_comb begin
    op = OP_NONE;
    if (sel_ok && rd_en && !wr_en) op = OP_ACQ;
    else if (sel_ok && wr_en && !rd_en) op = OP_REL;
  end

  always_comb begin
    for (int i = 0; i < NUM_LOCKS; i++) begin
      lock_hit[i] = (op != OP_NONE) && (lock_addr == AW'(i));
    end
  end

  assign any_hit = |lock_hit;

  always_comb begin
    AST_HIT_ONEHOT: assert ($onehot0(lock_hit)); // R8
    AST_HIT_NEEDS_SEL: assert (!any_hit || sel_ok); // R8
  end
endmodule

// File: rtl/hlu_entry.sv
module hlu_entry
  import hlu_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int IDW     = 2,
  parameter bit QUEUED  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  lock_op_e           op,
  input  logic [IDW-1:0]     req_id,
  output logic               grant,
  output logic [NUM_CPU-1:0] wake
);
  logic               held;
  logic [IDW-1:0]     owner;
  logic [NUM_CPU-1:0] waiting;
  logic [IDW-1:0]     next_id;
  logic               is_owner;
  logic               acq;
  logic               release_ok;
  logic               hand_over;

  always_comb begin
    next_id = '0;
    for (int i = NUM_CPU - 1; i >= 0; i--) begin
      if (waiting[i]) next_id = IDW'(i);
    end
  end

  assign acq        = hit && (op == OP_ACQ);
  assign is_owner   = held && (owner == req_id);
  assign grant      = acq && !held;
  assign release_ok = hit && (op == OP_REL) && is_owner;
  assign hand_over  = release_ok && (waiting != '0);

  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) begin
      wake[i] = hand_over && (next_id == IDW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= 1'b0;
      owner   <= '0;
      waiting <= '0;
    end else if (grant) begin
      held  <= 1'b1;
      owner <= req_id;
    end else if (acq && held && !is_owner && QUEUED) begin
      waiting[req_id] <= 1'b1;
    end else if (hand_over) begin
      owner            <= next_id;
      waiting[next_id] <= 1'b0;
    end else if (release_ok) begin
      held <= 1'b0;
    end
  end

  AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> held && (owner == $past(req_id))); // R2
  AST_OWNER_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !waiting[owner]); // R3
  AST_FREE_NO_WAITERS: assert property (@(posedge clk) disable iff (!rst_n)
    !held |-> (waiting == '0)); // R6
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_REL && held && owner != req_id) |=> held && $stable(owner)); // R4
  AST_SHORT_NO_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    !QUEUED |-> (waiting == '0) && (wake == '0)); // R7
endmodule

// File: rtl/hw_lock_unit.sv
module hw_lock_unit
  import hlu_pkg::*;
#(
  parameter int NUM_CPU     = 4,
  parameter int SHORT_LOCKS = 64,
  parameter int LONG_LOCKS  = 64,
  localparam int NUM_LOCKS  = SHORT_LOCKS + LONG_LOCKS,
  localparam int AW         = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
  localparam int IDW        = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] cpu_sel,
  input  logic [AW-1:0]      lock_addr,
  input  logic               rd_en,
  input  logic               wr_en,
  output logic               rd_grant,
  output logic [NUM_CPU-1:0] cpu_irq
);
  lock_op_e               op;
  logic [IDW-1:0]         req_id;
  logic [NUM_LOCKS-1:0]   lock_hit;
  logic [NUM_LOCKS-1:0]   grant_v;
  logic [NUM_CPU-1:0]     wake_v [NUM_LOCKS];
  logic [NUM_CPU-1:0]     wake_any;

  hlu_decode #(
    .NUM_CPU(NUM_CPU), .NUM_LOCKS(NUM_LOCKS), .AW(AW), .IDW(IDW)
  ) u_dec (
    .cpu_sel(cpu_sel), .lock_addr(lock_addr), .rd_en(rd_en), .wr_en(wr_en),
    .op(op), .req_id(req_id), .lock_hit(lock_hit)
  );

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    hlu_entry #(
      .NUM_CPU(NUM_CPU), .IDW(IDW), .QUEUED(g >= SHORT_LOCKS)
    ) u_ent (
      .clk(clk), .rst_n(rst_n), .hit(lock_hit[g]), .op(op), .req_id(req_id),
      .grant(grant_v[g]), .wake(wake_v[g])
    );
  end

  always_comb begin
    wake_any = '0;
    for (int i = 0; i < NUM_LOCKS; i++) wake_any |= wake_v[i];
  end

  assign rd_grant = |grant_v;

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_irq <= '0;
    else        cpu_irq <= wake_any;
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_irq)); // R9
  AST_GRANT_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> rd_en && !wr_en); // R8
  AST_IRQ_FROM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq != '0) |-> $past(wr_en && !rd_en)); // R6
endmodule

// File: tb/sim_hw_lock_unit.sv
`timescale 1ns/1ps
module sim_hw_lock_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cpu_sel = '0;
  logic [6:0] lock_addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_grant;
  logic [3:0] cpu_irq;

  always #2 clk = ~clk;

  hw_lock_unit #(.NUM_CPU(4), .SHORT_LOCKS(64), .LONG_LOCKS(64)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .lock_addr(lock_addr),
    .rd_en(rd_en), .wr_en(wr_en), .rd_grant(rd_grant), .cpu_irq(cpu_irq)
  );

  typedef struct {
    string      tag;
    bit         exp_g;
    logic [3:0] exp_irq;
  } item_t;

  item_t      sbq[$];
  logic [3:0] irq_due = '0;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  localparam logic [6:0] LNG = 7'd70;
  localparam logic [6:0] SHT = 7'd5;
  localparam logic [6:0] AUX = 7'd9;

  task automatic cyc(input string tag, input logic [3:0] sel, input logic [6:0] a,
                     input bit r, input bit w, input bit eg, input logic [3:0] nirq);
    item_t it;
    @(negedge clk);
    cpu_sel = sel; lock_addr = a; rd_en = r; wr_en = w;
    it.tag = tag; it.exp_g = eg; it.exp_irq = irq_due;
    sbq.push_back(it);
    irq_due = nirq;
  endtask

  task automatic idle(input string tag, input logic [3:0] nirq);
    cyc(tag, 4'b0000, 7'd0, 1'b0, 1'b0, 1'b0, nirq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_sel = '0; rd_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_due = '0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        n_cmp++;
        if (rd_grant !== it.exp_g) begin
          n_bad++;
          $display("FAIL %s: rd_grant=%0b expected %0b", it.tag, rd_grant, it.exp_g);
        end
        n_cmp++;
        if (cpu_irq !== it.exp_irq) begin
          n_bad++;
          $display("FAIL %s: cpu_irq=%b expected %b", it.tag, cpu_irq, it.exp_irq);
        end
      end
    end
  end

  initial begin : watchdog
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    do_reset();
    idle("R1 idle after reset", 4'b0000);
    cyc("R1 short lock free after reset", 4'b0001, 7'd0, 1, 0, 1, 0);
    cyc("R1 long lock free after reset", 4'b1000, LNG, 1, 0, 1, 0);
    cyc("R5 release long lock", 4'b1000, LNG, 0, 1, 0, 0);

    // long lock contention
    cyc("R2 cpu0 takes long lock", 4'b0001, LNG, 1, 0, 1, 0);
    cyc("R3 cpu2 refused", 4'b0100, LNG, 1, 0, 0, 0);
    cyc("R3 cpu1 refused", 4'b0010, LNG, 1, 0, 0, 0);
    cyc("R3 owner re-read refused", 4'b0001, LNG, 1, 0, 0, 0);
    cyc("R4 foreign write ignored", 4'b1000, LNG, 0, 1, 0, 0);
    cyc("R4 lock still held", 4'b1000, LNG, 1, 0, 0, 0);
    // waiters now cpu1, cpu2, cpu3; owner cpu0 not queued
    cyc("R6 owner release hands to cpu1", 4'b0001, LNG, 0, 1, 0, 4'b0010);
    idle("R6 irq pulse to cpu1", 4'b0000);
    idle("R6 irq pulse is one cycle", 4'b0000);
    cyc("R4 old owner write ignored", 4'b0001, LNG, 0, 1, 0, 0);
    cyc("R3 cpu0 queues", 4'b0001, LNG, 1, 0, 0, 0);
    cyc("R6 cpu1 release hands to cpu0", 4'b0010, LNG, 0, 1, 0, 4'b0001);
    cyc("R6 cpu0 release hands to cpu2", 4'b0001, LNG, 0, 1, 0, 4'b0100);
    cyc("R6 cpu2 release hands to cpu3", 4'b0100, LNG, 0, 1, 0, 4'b1000);
    cyc("R5 cpu3 release frees", 4'b1000, LNG, 0, 1, 0, 0);
    cyc("R5 lock free again", 4'b0010, LNG, 1, 0, 1, 0);
    cyc("R5 cpu1 release", 4'b0010, LNG, 0, 1, 0, 0);

    // short lock
    cyc("R2 cpu1 takes short lock", 4'b0010, SHT, 1, 0, 1, 0);
    cyc("R7 cpu2 refused on short", 4'b0100, SHT, 1, 0, 0, 0);
    cyc("R7 cpu0 refused on short", 4'b0001, SHT, 1, 0, 0, 0);
    cyc("R7 owner release frees short", 4'b0010, SHT, 0, 1, 0, 0);
    idle("R7 no irq after short release", 4'b0000);
    cyc("R7 short lock free", 4'b0100, SHT, 1, 0, 1, 0);
    cyc("R7 cpu2 releases short", 4'b0100, SHT, 0, 1, 0, 0);

    // access qualification
    cyc("R8 multi-select read ignored", 4'b0011, AUX, 1, 0, 0, 0);
    cyc("R8 no-select read ignored", 4'b0000, AUX, 1, 0, 0, 0);
    cyc("R8 lock untouched", 4'b0001, AUX, 1, 0, 1, 0);
    cyc("R8 both enables ignored", 4'b0001, AUX, 1, 1, 0, 0);
    cyc("R8 still held", 4'b0010, AUX, 1, 0, 0, 0);
    cyc("R8 multi-select write ignored", 4'b0011, AUX, 0, 1, 0, 0);
    cyc("R8 still held after bad write", 4'b0100, AUX, 1, 0, 0, 0);
    cyc("R5 cpu0 releases aux", 4'b0001, AUX, 0, 1, 0, 0);

    // reset while held with waiters
    cyc("R2 cpu0 takes long lock", 4'b0001, LNG, 1, 0, 1, 0);
    cyc("R3 cpu1 queues", 4'b0010, LNG, 1, 0, 0, 0);
    idle("pre-reset idle", 4'b0000);
    do_reset();
    idle("R1 no irq after reset", 4'b0000);
    cyc("R1 lock free after reset", 4'b0010, LNG, 1, 0, 1, 0);
    cyc("R1 cpu1 release with no waiters", 4'b0010, LNG, 0, 1, 0, 0);
    idle("R1 no waiter was kept", 4'b0000);
    idle("drain", 4'b0000);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule